// File: doc/BRIEF.md
# Programmable Almost-Flag Offset Loader

This block sits beside a FIFO and holds the two thresholds that drive its almost-empty and almost-full flags. Each threshold is wider than a byte. Software reaches both through one byte-wide data port, as four byte slots visited in a fixed rotating order: empty threshold low byte, empty threshold high byte, full threshold low byte, full threshold high byte, then back to the start. A load strobe, combined with the FIFO's write enable, writes the next slot. The same strobe, combined with the FIFO's two read enables, returns the next slot on the output byte.

The write position and the read position are separate counters. Each is kept while the strobe is released, so a caller can program a subset of the slots and carry on later from where it stopped. The FIFO's storage and its empty and full logic are outside the block. Occupancy (written minus read words) comes in as an input. The block compares occupancy and free space with the assembled thresholds and drives two active-low registered flags. Both the loading side and the readback side run on the same clock.

Top module: `almost_flag_loader`

## Requirements
- R1: A clock edge with `rst_n` low clears both slot positions to slot 0, sets both low bytes to 0x07 and both high bytes to 0, clears `dout` to 0, drives `pae_n` low and drives `paf_n` high.
- R2: A load happens on a clock edge where `load_n` and `wen1_n` are both low. The load writes `din` into the slot at the write position, then advances that position. The slots are 0 = empty low byte, 1 = empty high byte, 2 = full low byte and 3 = full high byte. The fifth load wraps to slot 0.
- R3: The write position does not change on edges without a load, so loading resumes at the next slot after a pause.
- R4: A readback happens on an edge where `load_n`, `ren1_n` and `ren2_n` are all low and no load takes place. The readback places the slot at the read position on `dout`, then advances the read position through the same order as loads. `dout` holds its value on every other edge.
- R5: When a load and a readback are requested on the same edge, only the load happens. `dout` keeps its value and the read position does not advance.
- R6: A high-byte slot stores only its low MSB_W = DEPTH_LOG2-8 bits (7 by default). Readback returns those bits with zeros above them.
- R7: `pae_n` is registered. After each edge it is low exactly when the occupancy sampled at that edge is at or below the empty threshold {slot1, slot0}.
- R8: `paf_n` is registered. After each edge it is low exactly when 2^DEPTH_LOG2 minus the sampled occupancy is at or below the full threshold {slot3, slot2}.
- R9: With `load_n` high, `wen1_n` low writes no slot, and the write position does not move.
- R10: With `load_n` high, low read enables leave `dout` unchanged and do not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for loading, readback and flags |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Active-low strobe selecting threshold slot access |
| wen1_n | input | 1 | Active-low write enable shared with the FIFO |
| ren1_n | input | 1 | Active-low read enable 1 shared with the FIFO |
| ren2_n | input | 1 | Active-low read enable 2 shared with the FIFO |
| din | input | 8 | Byte written into the current slot |
| occupancy | input | DEPTH_LOG2+1 | Words held in the FIFO, 0 to 2^DEPTH_LOG2 |
| dout | output | 8 | Byte read back from a slot |
| pae_n | output | 1 | Almost-empty flag, active low |
| paf_n | output | 1 | Almost-full flag, active low |

## Verification
The bench writes a subset of the slots, pauses with FIFO writes in progress, and then resumes. A design that reset its position when the strobe was released would overwrite slot 0 instead of continuing. A fifth load must land back in slot 0, and a simultaneous load and readback must leave `dout` and the read position alone. A design that let both actions through would show the loaded slot's neighbour early and then skip a slot on later readbacks. An all-ones byte written into a high slot must come back with its top bit clear. The flags are probed at occupancy equal to each threshold and one word past it, which exposes a strict comparison used where an inclusive one is needed.

// File: rtl/ofl_pkg.sv
// Shared types for the almost-flag offset loader.
// Assumes four byte slots visited in a fixed rotating order.
package ofl_pkg;
    typedef enum logic [1:0] {
        SLOT_E_LO = 2'd0,
        SLOT_E_HI = 2'd1,
        SLOT_F_LO = 2'd2,
        SLOT_F_HI = 2'd3
    } slot_e;

    localparam int NUM_SLOTS = 4;
    localparam logic [7:0] LO_RESET = 8'h07;
endpackage

// File: rtl/ofl_seq.sv
// Rotating slot position counter.
// It advances by one slot on each step pulse and wraps after the last slot.
// Assumes step_i is already qualified by the caller.
module ofl_seq
    import ofl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step_i,
    output slot_e pos_o
);
    // Advance the position on a qualified step; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_o <= SLOT_E_LO;
        else if (step_i)
            pos_o <= slot_e'(2'(pos_o + 2'd1));
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(pos_o));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && pos_o == SLOT_F_HI) |=> (pos_o == SLOT_E_LO));
endmodule

// File: rtl/ofl_bank.sv
// Storage for the two thresholds. Each threshold is a full low byte plus a
// narrowed high byte. Writes select a slot; the readback byte is a
// combinational mux on the read slot.
// Assumes BYTE_W == 8 and 1 <= MSB_W <= BYTE_W.
module ofl_bank
    import ofl_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int MSB_W  = 7,
    localparam int OFF_W = BYTE_W + MSB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  slot_e             wslot_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  slot_e             rslot_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic [OFF_W-1:0]  empty_off_o,
    output logic [OFF_W-1:0]  full_off_o
);
    localparam int NUM_THR = NUM_SLOTS / 2;

    logic [NUM_SLOTS-1:0][BYTE_W-1:0] slot_bytes;
    logic [NUM_THR-1:0][OFF_W-1:0]    thr;

    for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
        localparam slot_e LO_SLOT = slot_e'(2'(2 * g));
        localparam slot_e HI_SLOT = slot_e'(2'(2 * g + 1));
        logic [BYTE_W-1:0] lo_q;
        logic [MSB_W-1:0]  hi_q;

        // Low byte of this threshold: load when its slot is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lo_q <= BYTE_W'(LO_RESET);
            else if (we_i && wslot_i == LO_SLOT)
                lo_q <= wdata_i;
        end

        // High byte of this threshold: keep only the used bits.
        always_ff @(posedge clk) begin
            if (!rst_n)
                hi_q <= '0;
            else if (we_i && wslot_i == HI_SLOT)
                hi_q <= wdata_i[MSB_W-1:0];
        end

        // Expose the bytes for readback and the assembled threshold.
        always_comb begin
            slot_bytes[2*g]   = lo_q;
            slot_bytes[2*g+1] = BYTE_W'(hi_q);
            thr[g]            = {hi_q, lo_q};
        end
    end

    // Readback mux and threshold outputs.
    always_comb begin
        rdata_o     = slot_bytes[rslot_i];
        empty_off_o = thr[0];
        full_off_o  = thr[1];
    end

    assert_lo_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wslot_i == SLOT_E_LO) |=> (slot_bytes[0] == $past(wdata_i)));

    assert_hi_trim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wslot_i == SLOT_F_HI) |=>
        (slot_bytes[3] == ($past(wdata_i) & BYTE_W'((1 << MSB_W) - 1))));
endmodule

// File: rtl/ofl_flags.sv
// Registered almost-empty and almost-full comparators.
// Assumes occupancy never exceeds DEPTH.
module ofl_flags #(
    parameter int CNT_W = 16,
    parameter int OFF_W = 15,
    parameter int DEPTH = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] occ_i,
    input  logic [OFF_W-1:0] empty_off_i,
    input  logic [OFF_W-1:0] full_off_i,
    output logic             pae_n_o,
    output logic             paf_n_o
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] free_words;
    logic             near_empty;
    logic             near_full;

    // Free space and threshold comparisons (inclusive).
    always_comb begin
        free_words = DEPTH_C - occ_i;
        near_empty = (occ_i <= CNT_W'(empty_off_i));
        near_full  = (free_words <= CNT_W'(full_off_i));
    end

    // Register the flags; reset reports an empty FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pae_n_o <= 1'b0;
            paf_n_o <= 1'b1;
        end else begin
            pae_n_o <= !near_empty;
            paf_n_o <= !near_full;
        end
    end

    assert_empty_fifo_pae_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_i == '0) |=> !pae_n_o);

    assert_full_fifo_paf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_i == DEPTH_C) |=> !paf_n_o);
endmodule

// File: rtl/almost_flag_loader.sv
// Top of the almost-flag offset loader. It qualifies load and readback
// requests, with load taking priority, and keeps separate write and read
// slot positions. It registers the readback byte and drives the two
// threshold flags. Assumes 9 <= DEPTH_LOG2 <= 16 and a single clock for all
// access.
module almost_flag_loader
    import ofl_pkg::*;
#(
    parameter int DEPTH_LOG2 = 15,
    parameter int BYTE_W     = 8,
    localparam int MSB_W     = DEPTH_LOG2 - BYTE_W,
    localparam int OFF_W     = BYTE_W + MSB_W,
    localparam int CNT_W     = DEPTH_LOG2 + 1,
    localparam int DEPTH     = 1 << DEPTH_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wen1_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic [BYTE_W-1:0] din,
    input  logic [CNT_W-1:0]  occupancy,
    output logic [BYTE_W-1:0] dout,
    output logic              pae_n,
    output logic              paf_n
);
    logic              load_fire;
    logic              read_fire;
    slot_e             wpos;
    slot_e             rpos;
    logic [BYTE_W-1:0] rd_byte;
    logic [OFF_W-1:0]  empty_off;
    logic [OFF_W-1:0]  full_off;

    // Request qualification: a load wins over a readback on the same edge.
    always_comb begin
        load_fire = !load_n && !wen1_n;
        read_fire = !load_n && !ren1_n && !ren2_n && !load_fire;
    end

    ofl_seq u_wseq (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (load_fire),
        .pos_o  (wpos)
    );

    ofl_seq u_rseq (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (read_fire),
        .pos_o  (rpos)
    );

    ofl_bank #(
        .BYTE_W (BYTE_W),
        .MSB_W  (MSB_W)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (load_fire),
        .wslot_i     (wpos),
        .wdata_i     (din),
        .rslot_i     (rpos),
        .rdata_o     (rd_byte),
        .empty_off_o (empty_off),
        .full_off_o  (full_off)
    );

    ofl_flags #(
        .CNT_W (CNT_W),
        .OFF_W (OFF_W),
        .DEPTH (DEPTH)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .occ_i       (occupancy),
        .empty_off_i (empty_off),
        .full_off_i  (full_off),
        .pae_n_o     (pae_n),
        .paf_n_o     (paf_n)
    );

    // Readback output register: capture the selected slot on a readback.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (read_fire)
            dout <= rd_byte;
    end

    assert_load_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !wen1_n && !ren1_n && !ren2_n) |=> $stable(dout));

    assert_no_strobe_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> $stable(dout));

    assert_hi_readback_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (read_fire && (rpos == SLOT_E_HI || rpos == SLOT_F_HI)) |=>
        ((dout >> MSB_W) == '0));
endmodule

// File: tb/tb_almost_flag_loader.sv
// Bench: directed corner cases followed by seeded random traffic, all
// checked against a behavioural model kept in the bench.
module tb_almost_flag_loader;
    localparam int DEPTH_LOG2 = 15;
    localparam int MSB_W      = DEPTH_LOG2 - 8;
    localparam int CNT_W      = DEPTH_LOG2 + 1;
    localparam int DEPTH      = 1 << DEPTH_LOG2;
    localparam int HI_MASK    = (1 << MSB_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_n = 1'b1;
    logic             wen1_n = 1'b1;
    logic             ren1_n = 1'b1;
    logic             ren2_n = 1'b1;
    logic [7:0]       din = '0;
    logic [CNT_W-1:0] occupancy = '0;
    logic [7:0]       dout;
    logic             pae_n;
    logic             paf_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int m_slot [4];
    int m_wpos;
    int m_rpos;
    int m_dout;
    int m_pae;
    int m_paf;

    always #10 clk = ~clk;

    almost_flag_loader #(.DEPTH_LOG2(DEPTH_LOG2)) dut (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .wen1_n(wen1_n),
        .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din), .occupancy(occupancy),
        .dout(dout), .pae_n(pae_n), .paf_n(paf_n)
    );

    function automatic int exp_pae(int occ);
        return (occ <= (m_slot[1] * 256 + m_slot[0])) ? 0 : 1;
    endfunction

    function automatic int exp_paf(int occ);
        return ((DEPTH - occ) <= (m_slot[3] * 256 + m_slot[2])) ? 0 : 1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive, update the model at the edge, compare at negedge.
    task automatic step(input bit rs, input bit ld, input bit w, input bit r1,
                        input bit r2, input int d, input int occ);
        rst_n = rs; load_n = ld; wen1_n = w; ren1_n = r1; ren2_n = r2;
        din = 8'(d); occupancy = CNT_W'(occ);
        @(posedge clk);
        if (!rs) begin
            m_slot[0] = 7; m_slot[1] = 0; m_slot[2] = 7; m_slot[3] = 0;
            m_wpos = 0; m_rpos = 0; m_dout = 0; m_pae = 0; m_paf = 1;
        end else begin
            m_pae = exp_pae(occ);
            m_paf = exp_paf(occ);
            if (!ld && !w) begin
                m_slot[m_wpos] = (m_wpos % 2 == 1) ? (d & HI_MASK) : (d & 255);
                m_wpos = (m_wpos + 1) % 4;
            end else if (!ld && !r1 && !r2) begin
                m_dout = m_slot[m_rpos];
                m_rpos = (m_rpos + 1) % 4;
            end
        end
        @(negedge clk);
        chk("R4 dout model", int'(dout), m_dout);
        chk("R7 pae_n model", int'(pae_n), m_pae);
        chk("R8 paf_n model", int'(paf_n), m_paf);
    endtask

    task automatic load(input int d);
        step(1, 0, 0, 1, 1, d, 0);
    endtask

    task automatic rd_expect(input string tag, input int exp);
        step(1, 0, 1, 0, 0, 0, 0);
        chk(tag, int'(dout), exp);
    endtask

    initial begin
        #(20 * 200000);
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        n_bad++;
        n_chk++;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        @(negedge clk);
        step(0, 1, 1, 1, 1, 0, 500);
        step(0, 1, 1, 1, 1, 0, 500);
        chk("R1 reset dout", int'(dout), 0);
        chk("R1 reset pae_n", int'(pae_n), 0);
        chk("R1 reset paf_n", int'(paf_n), 1);
        step(1, 1, 1, 1, 1, 0, 0);
        rd_expect("R1 reset slot0", 8'h07);
        rd_expect("R1 reset slot1", 0);
        rd_expect("R1 reset slot2", 8'h07);
        rd_expect("R1 reset slot3", 0);

        // R2: four loads in order, then readback in the same order.
        load(8'h11); load(8'h22); load(8'h33); load(8'h44);
        rd_expect("R2 slot0", 8'h11);
        rd_expect("R2 slot1", 8'h22);
        rd_expect("R2 slot2", 8'h33);
        rd_expect("R2 slot3", 8'h44);

        // R2: fifth load wraps to slot 0.
        load(8'h55);
        rd_expect("R2 wrap slot0", 8'h55);
        rd_expect("R2 wrap slot1", 8'h22);
        rd_expect("R2 wrap slot2", 8'h33);
        rd_expect("R2 wrap slot3", 8'h44);

        // R3 / R9: partial load, pause with FIFO writes, resume.
        load(8'h01);
        for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 1, 8'hEE, 0);
        load(8'h02);
        rd_expect("R9 slot0 kept", 8'h55);
        rd_expect("R3 slot1", 8'h01);
        rd_expect("R3 resume slot2", 8'h02);
        rd_expect("R9 slot3 kept", 8'h44);

        // R10: read enables without strobe leave dout and position alone.
        step(1, 1, 1, 0, 0, 0, 0);
        chk("R10 dout held", int'(dout), 8'h44);
        rd_expect("R10 position kept", 8'h55);

        // R5: load and readback together; load wins.
        step(1, 0, 0, 0, 0, 8'h03, 0);
        chk("R5 dout held", int'(dout), 8'h55);
        rd_expect("R5 read position kept", 8'h01);
        rd_expect("R5 load landed slot2", 8'h02);
        rd_expect("R5 load landed slot3", 8'h03);

        // R6: high byte keeps only MSB_W bits.
        load(8'h10); load(8'hFF);
        rd_expect("R6 slot0", 8'h10);
        rd_expect("R6 high byte trimmed", 8'h7F);

        // R7 / R8 boundaries with thresholds 0x120 and 0x240.
        step(0, 1, 1, 1, 1, 0, 0);
        step(1, 1, 1, 1, 1, 0, 0);
        load(8'h20); load(8'h01); load(8'h40); load(8'h02);
        step(1, 1, 1, 1, 1, 0, 288);
        chk("R7 pae_n at threshold", int'(pae_n), 0);
        step(1, 1, 1, 1, 1, 0, 289);
        chk("R7 pae_n above threshold", int'(pae_n), 1);
        step(1, 1, 1, 1, 1, 0, DEPTH - 576);
        chk("R8 paf_n at threshold", int'(paf_n), 0);
        step(1, 1, 1, 1, 1, 0, DEPTH - 577);
        chk("R8 paf_n below threshold", int'(paf_n), 1);
        step(1, 1, 1, 1, 1, 0, DEPTH);
        chk("R8 paf_n full", int'(paf_n), 0);
        step(1, 1, 1, 1, 1, 0, 0);
        chk("R7 pae_n empty", int'(pae_n), 0);

        // Seeded random traffic checked against the model.
        for (int i = 0; i < 2000; i++) begin
            int occ;
            int sel;
            sel = int'($urandom() % 8);
            case (sel)
                0: occ = 0;
                1: occ = DEPTH;
                2: occ = m_slot[1] * 256 + m_slot[0] + int'($urandom() % 3) - 1;
                3: occ = DEPTH - (m_slot[3] * 256 + m_slot[2]) + int'($urandom() % 3) - 1;
                default: occ = int'($urandom() % (DEPTH + 1));
            endcase
            if (occ < 0) occ = 0;
            if (occ > DEPTH) occ = DEPTH;
            step(($urandom() % 64) != 0, ($urandom() % 3) == 0,
                 ($urandom() % 2) == 0, ($urandom() % 4) != 0,
                 ($urandom() % 4) != 0, int'($urandom() % 256), occ);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule